// File: doc/BRIEF.md
# Serial Audio Output Port Timing Generator

This block is the master side of a stereo serial audio output. It runs from a master clock at 512 times the output sample rate and divides it down to three outputs: a bit clock, a left/right word clock and a serial data line. Each frame is 512 master-clock cycles long. The left half-frame comes first, with the word clock high. The right half-frame follows, with the word clock low.

Upstream logic supplies one left/right pair of 20-bit samples per frame. A one-cycle request strobe marks the last master-clock cycle of each frame, and the pair on the inputs at the end of that cycle is played out during the next frame. Three formats can be selected: left-justified, I2S and right-justified. The bit clock runs at 64 or 32 times the sample rate. At 32 times, each word is cut to its top 16 bits so that it fills the half-frame exactly.

A falling edge on the SYNC input restarts the frame counter, which lets several ports lock to one shared word clock. The sample pair that SYNC interrupts is flagged invalid. A bypass input masks SYNC completely.

Top module: `sai_out_port`

## Requirements
- R1: While reset is asserted, and after its release until the first master-clock edge, bclk=0, lrclk=1, sdata=0, req=0 and pair_valid=0.
- R2: Each frame is 512 master-clock cycles. lrclk is high for the first 256 cycles (left) and low for the last 256 (right). With bclk_x32=0 the bit period is 8 cycles, and with bclk_x32=1 it is 16 cycles. Within each bit period bclk is low in the first half and high in the second half.
- R3: sdata changes only at the start of a bit period, where bclk falls. It holds steady while bclk is high, except on the cycle where a SYNC restart takes effect.
- R4: With fmt=0 (left-justified), the MSB of the word goes out in the first bit slot of the half-frame. The remaining bits follow MSB first, and every slot after the word is 0.
- R5: With fmt=1 (I2S), slot 0 of each half-frame carries 0 and the word begins, MSB first, in slot 1.
- R6: With fmt=2 (right-justified), the word ends in the last slot of the half-frame and the leading slots carry 0. fmt=3 behaves like fmt=0.
- R7: With bclk_x32=1 (packed), the word is the top 16 bits of the 20-bit sample. In fmt 0 and fmt 2 these 16 bits fill all 16 slots, with the MSB at one lrclk edge and the LSB ending at the next. In fmt 1 the top 15 bits occupy slots 1 to 15.
- R8: req is high for exactly one master-clock cycle, the last cycle of each frame. left_in and right_in are captured at the end of that cycle and sent during the following frame, left word first.
- R9: sync is passed through two flip-flops, and a high-to-low change between them is a SYNC fall. On the edge that follows the first edge at which sync is seen low, the counter restarts. With bclk_x32=0 it restarts at slot 0 of the right half-frame, so lrclk is low from that edge on. With bclk_x32=1 it restarts 8 cycles before the right half-frame, so lrclk falls 8 cycles later.
- R10: pair_valid goes low at a SYNC restart and stays low until the next frame start, where it goes high as a fresh pair is loaded. After reset it is low until the first frame start.
- R11: While bypass=1, a SYNC fall has no effect. The counter, the outputs and pair_valid carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 512 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Format: 0 left-justified, 1 I2S, 2 right-justified, 3 as 0 |
| bclk_x32 | input | 1 | 1 selects a 32x bit clock (packed), 0 selects 64x |
| bypass | input | 1 | When high, SYNC falls are ignored |
| sync | input | 1 | Frame realignment input, active on its falling edge |
| left_in | input | W | Left sample, MSB first |
| right_in | input | W | Right sample, MSB first |
| req | output | 1 | One-cycle strobe asking for the next sample pair |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word clock, high for the left half-frame |
| sdata | output | 1 | Serial data, stable while bclk is high |
| pair_valid | output | 1 | The pair now being sent was loaded cleanly |

## Verification
The bench targets the slot positions that differ between formats: the empty first I2S slot, the zero padding ahead of a right-justified word, and the packed case where left- and right-justified must give identical streams. A design that gets the offset wrong would shift every bit by one slot or drop the MSB or LSB. SYNC falls are placed mid-frame in both bit-clock rates, so an off-by-one in the synchroniser latency or the wrong restart point would show up at once as a late or early lrclk fall. The pair_valid flag is checked after each restart, and a SYNC fall is also sent while bypass is high. A design that honoured it there would jump the word clock into the right half.

// File: rtl/sai_out_port.sv
module sai_out_port #(
  parameter int W  = 20,
  parameter int PW = 16
) (
  input  logic         mclk,
  input  logic         rst_n,
  input  logic [1:0]   fmt,
  input  logic         bclk_x32,
  input  logic         bypass,
  input  logic         sync,
  input  logic [W-1:0] left_in,
  input  logic [W-1:0] right_in,
  output logic         req,
  output logic         bclk,
  output logic         lrclk,
  output logic         sdata,
  output logic         pair_valid
);
  localparam int IW = $clog2(W);

  logic [8:0]   cnt;
  logic [W-1:0] lw, rw;
  logic         s1, s2, vld;

  wire sync_fall = s2 & ~s1 & ~bypass;
  wire [W-1:0] cur = cnt[8] ? rw : lw;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lw  <= '0;
      rw  <= '0;
      s1  <= 1'b0;
      s2  <= 1'b0;
      vld <= 1'b0;
    end else begin
      s1 <= sync;
      s2 <= s1;
      if (sync_fall) begin
        cnt <= bclk_x32 ? 9'd248 : 9'd256;
        vld <= 1'b0;
      end else begin
        cnt <= cnt + 9'd1;
        if (cnt == 9'd511) begin
          lw  <= left_in;
          rw  <= right_in;
          vld <= 1'b1;
        end
      end
    end
  end

  logic sd;
  always_comb begin
    int slot, k, len, lim;
    slot = bclk_x32 ? int'(cnt[7:4]) : int'(cnt[7:3]);
    len  = bclk_x32 ? PW : W;
    lim  = bclk_x32 ? 16 : 32;
    case (fmt)
      2'd1:    k = slot - 1;
      2'd2:    k = slot - (lim - len);
      default: k = slot;
    endcase
    sd = 1'b0;
    if (k >= 0 && k < len) sd = cur[IW'(W - 1 - k)];
  end

  assign bclk       = bclk_x32 ? cnt[3] : cnt[2];
  assign lrclk      = ~cnt[8];
  assign req        = (cnt == 9'd511);
  assign sdata      = sd;
  assign pair_valid = vld;

  // R3
  sdata_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (bclk && $past(bclk) && !$past(sync_fall)) |-> $stable(sdata));

  // R8
  req_pulse_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    req |=> !req);

  // R9
  sync_lr_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (sync_fall && !bclk_x32) |=> (!lrclk && !pair_valid));

  // R11
  bypass_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (s2 && !s1 && bypass) |=> (cnt == $past(cnt) + 9'd1));

  // R2
  lr_edge_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    ($changed(lrclk) && !$past(sync_fall)) |-> (!bclk && $past(bclk)));
endmodule

// File: tb/sai_out_port_bench.sv
module sai_out_port_bench;
  localparam int W = 20;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic bclk_x32 = 1'b0, bypass = 1'b0, sync = 1'b1;
  logic [W-1:0] left_in = '0, right_in = '0;
  logic req, bclk, lrclk, sdata, pair_valid;

  sai_out_port #(.W(W), .PW(16)) u_sai_out_port (
    .mclk(mclk), .rst_n(rst_n), .fmt(fmt), .bclk_x32(bclk_x32),
    .bypass(bypass), .sync(sync), .left_in(left_in), .right_in(right_in),
    .req(req), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .pair_valid(pair_valid));

  always #10 mclk = ~mclk;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  int mcnt = 0, ms1 = 0, ms2 = 0, mvld = 0;
  int ml = 0, mr = 0;
  bit jumped = 0;
  logic prev_bclk = 0, prev_sd = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cnt=%0d)", tag, act, exp, mcnt);
    end
  endtask

  function automatic int exp_bit();
    int blen, nsl, len, slot, start, w;
    blen  = bclk_x32 ? 16 : 8;
    nsl   = bclk_x32 ? 16 : 32;
    len   = bclk_x32 ? 16 : 20;
    slot  = (mcnt % 256) / blen;
    w     = ((mcnt >= 256) ? mr : ml) >> (20 - len);
    start = (fmt == 2'd1) ? 1 : (fmt == 2'd2) ? nsl - len : 0;
    if (slot >= start && slot - start < len) return (w >> (len - 1 - (slot - start))) & 1;
    return 0;
  endfunction

  function automatic string fmt_tag();
    if (bclk_x32) return "R7";
    case (fmt)
      2'd1: return "R5";
      2'd2: return "R6";
      2'd3: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic compare();
    int blen;
    blen = bclk_x32 ? 16 : 8;
    chk("R2 bclk", int'(bclk), ((mcnt % blen) >= blen / 2) ? 1 : 0);
    chk("R2 lrclk", int'(lrclk), (mcnt < 256) ? 1 : 0);
    chk({fmt_tag(), " sdata"}, int'(sdata), exp_bit());
    chk("R8 req", int'(req), (mcnt == 511) ? 1 : 0);
    chk("R10 pair_valid", int'(pair_valid), mvld);
    if (bclk && prev_bclk && !jumped) chk("R3 sdata hold", int'(sdata), int'(prev_sd));
    prev_bclk = bclk;
    prev_sd   = sdata;
  endtask

  task automatic tick();
    bit fall;
    @(posedge mclk);
    fall = (ms2 == 1) && (ms1 == 0) && !bypass;
    ms2 = ms1;
    ms1 = int'(sync);
    jumped = fall;
    if (fall) begin
      mcnt = bclk_x32 ? 248 : 256;
      mvld = 0;
    end else begin
      if (mcnt == 511) begin
        ml = int'(left_in);
        mr = int'(right_in);
        mvld = 1;
      end
      mcnt = (mcnt + 1) % 512;
    end
    @(negedge mclk);
    compare();
    if (mcnt == 510) begin
      left_in  = W'($urandom);
      right_in = W'($urandom);
    end
  endtask

  task automatic run_frames(input int n);
    while (mcnt != 0) tick();
    for (int i = 0; i < n * 512; i++) tick();
  endtask

  task automatic wait_cnt(input int c);
    while (mcnt != c) tick();
  endtask

  always @(posedge mclk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    left_in  = 20'hA5C3F;
    right_in = 20'h1E07B;
    for (int i = 0; i < 4; i++) begin
      @(negedge mclk);
      chk("R1 bclk", int'(bclk), 0);
      chk("R1 lrclk", int'(lrclk), 1);
      chk("R1 sdata", int'(sdata), 0);
      chk("R1 req", int'(req), 0);
      chk("R1 pair_valid", int'(pair_valid), 0);
    end
    rst_n = 1'b1;
    compare();

    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 4; f++) begin
        while (mcnt != 0) tick();
        bclk_x32 = m[0];
        fmt = f[1:0];
        run_frames(2);
      end
    end

    // R9: 64x restart mid left half
    bclk_x32 = 1'b0; fmt = 2'd0;
    run_frames(1);
    wait_cnt(100);
    sync = 1'b0;
    tick();
    chk("R9 lrclk before restart", int'(lrclk), 1);
    tick();
    chk("R9 lrclk low after restart", int'(lrclk), 0);
    chk("R10 invalid after restart", int'(pair_valid), 0);
    for (int i = 0; i < 40; i++) tick();
    sync = 1'b1;
    run_frames(2);
    chk("R10 valid again", int'(pair_valid), 1);

    // R9: 32x restart
    bclk_x32 = 1'b1; fmt = 2'd2;
    run_frames(1);
    wait_cnt(60);
    sync = 1'b0;
    for (int i = 0; i < 9; i++) tick();
    chk("R9 32x lrclk still high", int'(lrclk), 1);
    tick();
    chk("R9 32x lrclk falls", int'(lrclk), 0);
    sync = 1'b1;
    run_frames(2);

    // R11: SYNC ignored under bypass
    bclk_x32 = 1'b0; fmt = 2'd1;
    run_frames(1);
    wait_cnt(100);
    bypass = 1'b1;
    sync = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    chk("R11 lrclk unaffected", int'(lrclk), 1);
    chk("R11 pair_valid unaffected", int'(pair_valid), 1);
    for (int i = 0; i < 8; i++) tick();
    bypass = 1'b0;
    sync = 1'b1;
    run_frames(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule